// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the host-side register file of a dual-tone signalling transceiver. A host reaches it over a 4-bit data bus. Each access is framed by chip select, a read/write level, one register-select line and a positive pulse on a bus clock input. The block works in the system clock domain. It samples the bus lines, finds the end of each bus clock pulse, and commits the access at that point.

Two control registers hold the tone and interrupt settings. Both share the control address. The second one is reached only after a write to the first one sets a one-shot redirect bit. A status nibble gathers strobes from the tone receiver and the tone generator. Its event flags clear themselves when a status read completes. An active-low, open-drain style interrupt request is modelled as a pull-low enable. Depending on the mode, it shows the interrupt flag or passes a filtered call-progress square wave straight through.

Top module: `tone_xcvr_regs`

## Requirements
- R1: `dout_oe` is high only while `cs`, `bus_clk` and `rw` are all high. `dout` then shows the receive data when `rs`=0, and the status nibble when `rs`=1. The status nibble is {b3 no-tone, b2 receive full, b1 transmit ready, b0 interrupt flag}.
- R2: A write with `rs`=0 (`rw`=0) stores `din` into `tx_digit` at the falling edge of `bus_clk`. `tx_load` pulses for exactly one clock.
- R3: A control write (`rs`=1, `rw`=0) with the redirect bit clear loads register A: `tone_en`=b0, `cp_mode`=b1, `irq_en`=b2. If b3=1, the redirect bit is set.
- R4: While the redirect bit is set, the next control write loads register B instead: `burst_mode`=b0, `single_tone`=b2, `row_col`=b3. Register A is left unchanged and the redirect bit clears, so the following control write goes to A again.
- R5: `rx_valid` stores `rx_digit` and sets b2. `tx_ready` sets b1. Either one also sets b0 when `irq_en`=1 and `cp_mode`=0.
- R6: Completing a status read (falling `bus_clk`) clears b0, b1 and b2 and leaves b3 alone.
- R7: `rx_no_tone` sets b3. `rx_valid` clears b3, and the clear wins if both arrive in the same cycle.
- R8: A flag set in the same cycle as a status-read completion stays set.
- R9: With `irq_en`=0, `irq_pull` is 0. With `irq_en`=1 and `cp_mode`=0, it follows b0. With `irq_en`=1 and `cp_mode`=1, it equals the inverse of `cp_wave`.
- R10: After reset, all control bits, status flags and data registers are 0, `irq_pull` is 0 and `dout_oe` is 0.
- R11: A bus pulse with `cs` low changes no register and does not enable `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cs | input | 1 | chip select, active high |
| bus_clk | input | 1 | host access pulse |
| rw | input | 1 | 1 = read, 0 = write |
| rs | input | 1 | register select: 0 data, 1 control/status |
| din | input | 4 | host write data |
| dout | output | 4 | host read data |
| dout_oe | output | 1 | read data drive enable |
| rx_valid | input | 1 | receiver strobe: valid digit |
| rx_digit | input | 4 | received digit code |
| rx_no_tone | input | 1 | receiver strobe: no tone for the set time |
| tx_ready | input | 1 | generator strobe: ready for next digit |
| cp_wave | input | 1 | filtered call-progress square wave |
| tx_digit | output | 4 | digit to transmit |
| tx_load | output | 1 | one-clock pulse on a new transmit digit |
| tone_en | output | 1 | tone output enable |
| cp_mode | output | 1 | call-progress mode select |
| irq_en | output | 1 | interrupt enable |
| burst_mode | output | 1 | burst timing select |
| single_tone | output | 1 | single-tone select |
| row_col | output | 1 | row/column choice in single-tone mode |
| irq_pull | output | 1 | 1 = pull the interrupt line low |

## Verification
The collision that matters is a receiver or generator strobe landing in the same clock as a status-read completion, where a set and a self-clear compete for the same flag. The bench holds a status read open, then drops `bus_clk` on the same negative clock edge that raises `rx_valid`. It judges the result by a second status read, which must still show receive-full and the interrupt flag. A second collision is `rx_valid` together with `rx_no_tone`. There the bench expects b3 to read back as 0.

// File: rtl/tone_xcvr_pkg.sv
package tone_xcvr_pkg;
  localparam int NIB = 4;
  typedef logic [NIB-1:0] nib_t;

  typedef struct packed {
    logic irq_en;
    logic cp_mode;
    logic tone_en;
  } ctl_a_t;

  typedef struct packed {
    logic row_col;
    logic single;
    logic burst;
  } ctl_b_t;

  // set has priority over clear so that no event is lost
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic nib_t pack_status(logic no_tone, logic rx_full,
                                       logic tx_rdy, logic irq_f);
    return {no_tone, rx_full, tx_rdy, irq_f};
  endfunction
endpackage

// File: rtl/txr_bus_front.sv
module txr_bus_front
  import tone_xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic bus_clk,
  input  logic rw,
  input  logic rs,
  input  nib_t din,
  output logic wr_tx,
  output logic wr_ctl,
  output logic rd_stat_end,
  output nib_t wdata
);
  logic bclk_q, cs_q, rw_q, rs_q;
  nib_t din_q;
  logic acc_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      cs_q   <= 1'b0;
      rw_q   <= 1'b0;
      rs_q   <= 1'b0;
      din_q  <= '0;
    end else begin
      bclk_q <= bus_clk;
      cs_q   <= cs;
      rw_q   <= rw;
      rs_q   <= rs;
      din_q  <= din;
    end
  end

  // access commits on the falling edge of the bus pulse
  assign acc_end     = bclk_q & ~bus_clk & cs_q;
  assign wr_tx       = acc_end & ~rw_q & ~rs_q;
  assign wr_ctl      = acc_end & ~rw_q &  rs_q;
  assign rd_stat_end = acc_end &  rw_q &  rs_q;
  assign wdata       = din_q;

  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({wr_tx, wr_ctl, rd_stat_end}) <= 1);
endmodule

// File: rtl/txr_ctrl_regs.sv
module txr_ctrl_regs
  import tone_xcvr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_tx,
  input  logic   wr_ctl,
  input  nib_t   wdata,
  output ctl_a_t ctl_a,
  output ctl_b_t ctl_b,
  output nib_t   tx_digit,
  output logic   tx_load
);
  logic b_sel;
  logic wr_a, wr_b;

  assign wr_b = wr_ctl &  b_sel;
  assign wr_a = wr_ctl & ~b_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a    <= '0;
      ctl_b    <= '0;
      b_sel    <= 1'b0;
      tx_digit <= '0;
      tx_load  <= 1'b0;
    end else begin
      tx_load <= wr_tx;
      if (wr_tx) tx_digit <= wdata;
      if (wr_a) begin
        ctl_a <= '{irq_en: wdata[2], cp_mode: wdata[1], tone_en: wdata[0]};
        b_sel <= wdata[3];
      end
      if (wr_b) begin
        ctl_b <= '{row_col: wdata[3], single: wdata[2], burst: wdata[0]};
        b_sel <= 1'b0;
      end
    end
  end

  p_redirect_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> (!b_sel && $stable(ctl_a)));

  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_tx) |=> !tx_load);
endmodule

// File: rtl/txr_status_flags.sv
module txr_status_flags
  import tone_xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  nib_t rx_digit,
  input  logic rx_no_tone,
  input  logic tx_ready,
  input  logic rd_stat_end,
  input  logic int_arm,
  output nib_t status,
  output nib_t rx_data
);
  logic f_irq, f_tx, f_rx, f_nt;
  logic irq_evt;

  assign irq_evt = int_arm & (rx_valid | tx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_irq   <= 1'b0;
      f_tx    <= 1'b0;
      f_rx    <= 1'b0;
      f_nt    <= 1'b0;
      rx_data <= '0;
    end else begin
      f_irq <= flag_next(f_irq, irq_evt,  rd_stat_end);
      f_tx  <= flag_next(f_tx,  tx_ready, rd_stat_end);
      f_rx  <= flag_next(f_rx,  rx_valid, rd_stat_end);
      // valid tone clears no-tone and wins over a simultaneous set
      f_nt  <= ~rx_valid & (rx_no_tone | f_nt);
      if (rx_valid) rx_data <= rx_digit;
    end
  end

  assign status = pack_status(f_nt, f_rx, f_tx, f_irq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> f_rx);
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_end && !rx_valid && !tx_ready) |=> (status[2:0] == 3'b000));
  p_nt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !f_nt);
  p_nt_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (f_nt && !rx_valid) |=> f_nt);
endmodule

// File: rtl/txr_irq_out.sv
module txr_irq_out
  import tone_xcvr_pkg::*;
(
  input  ctl_a_t ctl_a,
  input  logic   irq_flag,
  input  logic   cp_wave,
  output logic   irq_pull
);
  always_comb begin
    irq_pull = 1'b0;
    if (ctl_a.irq_en) irq_pull = ctl_a.cp_mode ? ~cp_wave : irq_flag;
  end
endmodule

// File: rtl/tone_xcvr_regs.sv
module tone_xcvr_regs
  import tone_xcvr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       bus_clk,
  input  logic       rw,
  input  logic       rs,
  input  logic [3:0] din,
  output logic [3:0] dout,
  output logic       dout_oe,
  input  logic       rx_valid,
  input  logic [3:0] rx_digit,
  input  logic       rx_no_tone,
  input  logic       tx_ready,
  input  logic       cp_wave,
  output logic [3:0] tx_digit,
  output logic       tx_load,
  output logic       tone_en,
  output logic       cp_mode,
  output logic       irq_en,
  output logic       burst_mode,
  output logic       single_tone,
  output logic       row_col,
  output logic       irq_pull
);
  logic   wr_tx, wr_ctl, rd_stat_end;
  nib_t   wdata, status, rx_data;
  ctl_a_t ctl_a;
  ctl_b_t ctl_b;

  txr_bus_front u_front (
    .clk(clk), .rst_n(rst_n), .cs(cs), .bus_clk(bus_clk), .rw(rw), .rs(rs),
    .din(din), .wr_tx(wr_tx), .wr_ctl(wr_ctl), .rd_stat_end(rd_stat_end),
    .wdata(wdata)
  );

  txr_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .wr_ctl(wr_ctl), .wdata(wdata),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .tx_digit(tx_digit), .tx_load(tx_load)
  );

  txr_status_flags u_stat (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_digit(rx_digit),
    .rx_no_tone(rx_no_tone), .tx_ready(tx_ready), .rd_stat_end(rd_stat_end),
    .int_arm(ctl_a.irq_en & ~ctl_a.cp_mode), .status(status), .rx_data(rx_data)
  );

  txr_irq_out u_irq (
    .ctl_a(ctl_a), .irq_flag(status[0]), .cp_wave(cp_wave), .irq_pull(irq_pull)
  );

  assign dout_oe     = cs & bus_clk & rw;
  assign dout        = dout_oe ? (rs ? status : rx_data) : '0;
  assign tone_en     = ctl_a.tone_en;
  assign cp_mode     = ctl_a.cp_mode;
  assign irq_en      = ctl_a.irq_en;
  assign burst_mode  = ctl_b.burst;
  assign single_tone = ctl_b.single;
  assign row_col     = ctl_b.row_col;

  p_irq_dtmf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !cp_mode && $rose(status[0])) |-> irq_pull);
  p_no_write_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |=> (!tx_load || !$past(rw)) );
endmodule

// File: tb/tone_xcvr_regs_test.sv
module tone_xcvr_regs_test;
  logic clk = 0, rst_n = 0;
  logic cs = 0, bus_clk = 0, rw = 0, rs = 0;
  logic [3:0] din = 0, rx_digit = 0;
  logic rx_valid = 0, rx_no_tone = 0, tx_ready = 0, cp_wave = 0;
  logic [3:0] dout, tx_digit;
  logic dout_oe, tx_load, tone_en, cp_mode, irq_en;
  logic burst_mode, single_tone, row_col, irq_pull;
  int n_run = 0, n_fail = 0, load_cnt = 0;

  always #2.5 clk = ~clk;

  tone_xcvr_regs uut (.*);

  // op: 0 write, 1 read, 2 rx_valid, 3 tx_ready, 4 no_tone,
  //     5 check A {ien,cp,tone}, 6 check B {rowcol,single,burst}, 7 irq, 8 tx_digit
  typedef struct packed { logic [3:0] op; logic rs; logic [3:0] val; logic [3:0] req; } vec_t;
  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{0,1,4'b0101,3},  // R3 A: tone_en, irq_en
    '{5,0,4'b0101,3},  // R3
    '{0,1,4'b1101,3},  // R3 A with redirect
    '{0,1,4'b1101,4},  // R4 goes to B
    '{6,0,4'b0111,4},  // R4
    '{5,0,4'b0101,4},  // R4 A unchanged
    '{0,1,4'b0100,4},  // R4 back to A
    '{5,0,4'b0100,4},  // R4
    '{6,0,4'b0111,4},  // R4 B unchanged
    '{2,0,4'hA,5},     // R5 rx digit
    '{1,0,4'hA,1},     // R1 read rx data
    '{1,1,4'b0101,5},  // R5 status b2,b0
    '{1,1,4'b0000,6},  // R6 cleared
    '{7,0,4'b0000,9},  // R9
    '{4,0,4'b0000,7},  // R7 no tone
    '{1,1,4'b1000,7},  // R7
    '{3,0,4'b0000,5},  // R5 tx ready
    '{7,0,4'b0001,9},  // R9
    '{1,1,4'b1011,5},  // R5
    '{1,1,4'b1000,6},  // R6 b3 kept
    '{2,0,4'h3,7},     // R7 valid clears b3
    '{1,1,4'b0101,7},  // R7
    '{0,0,4'h7,2},     // R2 tx write
    '{8,0,4'h7,2},     // R2
    '{1,0,4'h3,1}      // R1
  };

  task automatic chk(input int req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c, input logic r, input logic [3:0] d);
    @(negedge clk); cs = c; rw = 0; rs = r; din = d; bus_clk = 1;
    @(negedge clk); @(negedge clk); bus_clk = 0;
    load_cnt = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (tx_load) load_cnt++; end
    cs = 0;
  endtask

  task automatic bus_rd(input logic r, input int req, input logic [3:0] exp);
    @(negedge clk); cs = 1; rw = 1; rs = r; bus_clk = 1;
    @(negedge clk);
    chk(req, {3'b0, dout_oe}, 4'b0001);
    chk(req, dout, exp);
    bus_clk = 0;
    @(negedge clk); @(negedge clk); cs = 0; rw = 0;
  endtask

  task automatic pulse(input int which, input logic [3:0] d);
    @(negedge clk); rx_digit = d;
    if (which == 2) rx_valid = 1;
    if (which == 3) tx_ready = 1;
    if (which == 4) rx_no_tone = 1;
    @(negedge clk); rx_valid = 0; tx_ready = 0; rx_no_tone = 0;
    @(negedge clk);
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog actual hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(10, {irq_en, cp_mode, tone_en, dout_oe}, 4'b0000);
    chk(10, {row_col, single_tone, burst_mode, irq_pull}, 4'b0000);
    chk(10, tx_digit, 4'h0);
    bus_rd(1, 10, 4'b0000);
    bus_rd(0, 10, 4'b0000);

    for (int k = 0; k < NV; k++) begin
      case (VT[k].op)
        0: bus_wr(1, VT[k].rs, VT[k].val);
        1: bus_rd(VT[k].rs, int'(VT[k].req), VT[k].val);
        2, 3, 4: pulse(int'(VT[k].op), VT[k].val);
        5: chk(int'(VT[k].req), {1'b0, irq_en, cp_mode, tone_en}, VT[k].val);
        6: chk(int'(VT[k].req), {1'b0, row_col, single_tone, burst_mode}, VT[k].val);
        7: chk(int'(VT[k].req), {3'b0, irq_pull}, VT[k].val);
        default: chk(int'(VT[k].req), tx_digit, VT[k].val);
      endcase
    end

    // R2 single-cycle load pulse
    bus_wr(1, 0, 4'h9);
    chk(2, load_cnt[3:0], 4'd1);
    chk(2, tx_digit, 4'h9);

    // R11 cs low: no write, no drive
    bus_wr(0, 1, 4'b0111);
    chk(11, {1'b0, irq_en, cp_mode, tone_en}, 4'b0100);
    bus_wr(0, 0, 4'h1);
    chk(11, tx_digit, 4'h9);
    @(negedge clk); cs = 0; rw = 1; rs = 1; bus_clk = 1;
    @(negedge clk); chk(11, {3'b0, dout_oe}, 4'b0000); bus_clk = 0; rw = 0;

    // R8 strobe in the same cycle as a status-read completion
    @(negedge clk); cs = 1; rw = 1; rs = 1; bus_clk = 1;
    @(negedge clk); @(negedge clk);
    bus_clk = 0; rx_valid = 1; rx_digit = 4'h5;
    @(negedge clk); rx_valid = 0;
    @(negedge clk); cs = 0; rw = 0;
    bus_rd(1, 8, 4'b0101);
    bus_rd(1, 6, 4'b0000);

    // R7 valid and no-tone together: clear wins
    @(negedge clk); rx_valid = 1; rx_no_tone = 1; rx_digit = 4'hC;
    @(negedge clk); rx_valid = 0; rx_no_tone = 0;
    bus_rd(1, 7, 4'b0101);

    // R9 call-progress passthrough; R5 no interrupt flag in that mode
    bus_wr(1, 1, 4'b0110);
    cp_wave = 0; #1; chk(9, {3'b0, irq_pull}, 4'b0001);
    @(negedge clk); cp_wave = 1; #1; chk(9, {3'b0, irq_pull}, 4'b0000);
    pulse(2, 4'hE);
    bus_rd(1, 5, 4'b0100);
    // R9 interrupts disabled: line released even with flag events
    bus_wr(1, 1, 4'b0000);
    cp_wave = 0;
    pulse(3, 4'h0);
    #1; chk(9, {3'b0, irq_pull}, 4'b0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule